// File: doc/BRIEF.md
# Graphics Pattern Bank Mapper with Half Swap

This block sits between a video processor's 13-bit pattern-memory address and a character ROM that is larger than that address can reach. It divides the 8 KiB pattern space into two groups of windows. One group holds two windows of 2 KiB each. The other group holds four windows of 1 KiB each. Each window takes its bank number from a register that the CPU can write. A single swap bit in a control register chooses which 4 KiB half of the space each group covers.

The CPU writes the registers through an 8-bit port with address decode. The six bank registers sit at consecutive addresses starting at the base, and the control register sits directly after them. The ROM address is produced combinationally from the video address and the current register contents. The same control register also selects how the nametables are mirrored. The block turns that selection into the single nametable address bit that the video side needs.

Top module: `chr_bank_mapper`

## Requirements
- R1: After reset, all six bank registers and the control register read as 0. The swap bit is therefore 0 and mirroring is horizontal.
- R2: In a 2 KiB window, bit 0 of the bank register is ignored. ROM address bits 17..11 come from bank register bits 7..1, and ROM address bit 10 comes from video address bit 10.
- R3: In a 1 KiB window, all 8 bits of the bank register form ROM address bits 17..10.
- R4: ROM address bits 9..0 always equal video address bits 9..0.
- R5: With swap bit 0, video addresses $0000-$07FF use bank register 0 and $0800-$0FFF use bank register 1, both as 2 KiB windows. Addresses $1000, $1400, $1800 and $1C00 each begin a 1 KiB window, served by bank registers 2, 3, 4 and 5.
- R6: With swap bit 1, the effective bit 12 is video bit 12 XOR 1. The 2 KiB windows then cover $1000 (register 0) and $1800 (register 1). The 1 KiB windows cover $0000, $0400, $0800 and $0C00 (registers 2 to 5).
- R7: A CPU write with the write enable high to base+0 through base+5 (default $7EF0-$7EF5) loads bank register 0-5. The write takes effect at that clock edge.
- R8: A write to base+6 ($7EF6) loads the control register. Data bit 0 is mirroring (0 horizontal, 1 vertical) and bit 1 is the swap bit. Data bits 7..2 have no effect.
- R9: A write to any other address, or with the write enable low, changes no register.
- R10: The nametable output equals video address bit 11 when mirroring is horizontal, and video address bit 10 when it is vertical.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data |
| vid_addr | input | 13 | Video pattern-memory address |
| rom_addr | output | 18 | Character ROM address |
| nt_addr_bit | output | 1 | Nametable address bit chosen by mirroring |

## Verification
Some checks run on every cycle. They confirm that each register holds its value unless its own address is written, and that a write lands with the data of that write. They also confirm that the low ten offset bits pass through unchanged, that the window selected by the effective bit 12 supplies the upper ROM bits, and that the nametable bit follows the mirroring mode. Other behaviour only the bench scenarios can show. These are the complete window layout in each swap setting, the discarded low bit of the 2 KiB registers at real bank values, the masking of unused control data bits, the rejection of writes to neighbouring addresses, and the clearing of everything by a reset in the middle of a run.

// File: rtl/chr_map_pkg.sv
package chr_map_pkg;

   // Register file layout
   localparam int NUM_WIDE   = 2;              // 2 KiB windows
   localparam int NUM_NARROW = 4;              // 1 KiB windows
   localparam int NUM_BANKS  = NUM_WIDE + NUM_NARROW;
   localparam int CTRL_SLOT  = NUM_BANKS;      // control sits after banks
   localparam int NUM_SLOTS  = NUM_BANKS + 1;

   typedef enum logic {
      MIR_HORIZ = 1'b0,
      MIR_VERT  = 1'b1
   } mirror_e;

   typedef struct packed {
      logic    swap;
      mirror_e mir;
   } ctrl_t;

   localparam ctrl_t CTRL_RESET = '{swap: 1'b0, mir: MIR_HORIZ};

endpackage

// File: rtl/chr_bank_regs.sv
module chr_bank_regs
   import chr_map_pkg::*;
#(
   parameter int              ADDR_W = 16,
   parameter int              DATA_W = 8,
   parameter logic [ADDR_W-1:0] BASE = 16'h7EF0
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              we,
   input  logic [ADDR_W-1:0]                 addr,
   input  logic [DATA_W-1:0]                 wdata,
   output logic [NUM_BANKS-1:0][DATA_W-1:0]  bank_q,
   output ctrl_t                             ctrl_q
);

   // elaboration checks
   if (DATA_W < 2) begin : g_bad_dw
      $error("chr_bank_regs: DATA_W must be at least 2");
   end
   if (ADDR_W < 4) begin : g_bad_aw
      $error("chr_bank_regs: ADDR_W too small for register window");
   end

   // Offset from base; unsigned wrap makes addresses below base large.
   logic [ADDR_W-1:0] rel;
   logic              in_win;

   assign rel    = addr - BASE;
   assign in_win = we && (rel < ADDR_W'(NUM_SLOTS));

   for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
      logic sel;
      assign sel = in_win && (rel == ADDR_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   bank_q[i] <= '0;
         else if (sel) bank_q[i] <= wdata;
      end

      // R7: a write to this slot lands with that write's data
      a_r7_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
         (we && addr == BASE + ADDR_W'(i)) |=> bank_q[i] == $past(wdata));

      // R9: no write to this slot, no change
      a_r9_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !(we && addr == BASE + ADDR_W'(i)) |=> $stable(bank_q[i]));
   end

   logic ctrl_sel;
   assign ctrl_sel = in_win && (rel == ADDR_W'(CTRL_SLOT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RESET;
      end else if (ctrl_sel) begin
         ctrl_q.swap <= wdata[1];
         ctrl_q.mir  <= mirror_e'(wdata[0]);
      end
   end

   // R8: control takes only bits 1..0 of the written data
   a_r8_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == BASE + ADDR_W'(CTRL_SLOT)) |=>
         ({ctrl_q.swap, ctrl_q.mir} == $past(wdata[1:0])));

   // R9: control holds when not addressed
   a_r9_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && addr == BASE + ADDR_W'(CTRL_SLOT)) |=> $stable(ctrl_q));

endmodule

// File: rtl/chr_window_decode.sv
module chr_window_decode
   import chr_map_pkg::*;
#(
   parameter int VAW    = 13,
   parameter int BANK_W = 8,
   parameter int ROM_AW = 18
) (
   input  logic [VAW-1:0]                   vid_addr,
   input  logic [NUM_WIDE-1:0][BANK_W-1:0]  wide_bank,
   input  logic [NUM_NARROW-1:0][BANK_W-1:0] narrow_bank,
   input  logic                             swap,
   output logic [ROM_AW-1:0]                rom_addr
);

   // 1 KiB window offset width; the space holds 8 windows of that size
   localparam int OFS_W   = VAW - 3;
   localparam int NSEL_W  = $clog2(NUM_NARROW);
   localparam int WSEL_W  = (NUM_WIDE > 1) ? $clog2(NUM_WIDE) : 1;

   if (VAW < 4) begin : g_bad_vaw
      $error("chr_window_decode: VAW too small");
   end
   if (ROM_AW != BANK_W + OFS_W) begin : g_bad_rom
      $error("chr_window_decode: ROM_AW must equal BANK_W + VAW - 3");
   end
   if (NUM_NARROW != 4 || NUM_WIDE != 2) begin : g_bad_layout
      $error("chr_window_decode: layout expects two wide and four narrow windows");
   end

   logic              hi_half;       // effective bit 12 after swap
   logic [WSEL_W-1:0] wsel;
   logic [NSEL_W-1:0] nsel;
   logic [BANK_W-1:0] wide_num;
   logic [BANK_W-1:0] narrow_num;
   logic [BANK_W-1:0] bank_num;

   assign hi_half = vid_addr[VAW-1] ^ swap;
   assign wsel    = vid_addr[VAW-2 -: WSEL_W];
   assign nsel    = vid_addr[VAW-2 -: NSEL_W];

   // Wide window: drop register bit 0, replace with video bit OFS_W
   assign wide_num   = {wide_bank[wsel][BANK_W-1:1], vid_addr[OFS_W]};
   assign narrow_num = narrow_bank[nsel];

   always_comb begin
      if (hi_half) bank_num = narrow_num;
      else         bank_num = wide_num;
   end

   assign rom_addr = {bank_num, vid_addr[OFS_W-1:0]};

endmodule

// File: rtl/chr_mirror_sel.sv
module chr_mirror_sel
   import chr_map_pkg::*;
#(
   parameter int VAW = 13
) (
   input  logic [VAW-1:0] vid_addr,
   input  mirror_e        mir,
   output logic           nt_bit
);

   localparam int HBIT = VAW - 2;   // 2 KiB stride bit
   localparam int VBIT = VAW - 3;   // 1 KiB stride bit

   if (VAW < 4) begin : g_bad_vaw
      $error("chr_mirror_sel: VAW too small");
   end

   always_comb begin
      unique case (mir)
         MIR_VERT:  nt_bit = vid_addr[VBIT];
         default:   nt_bit = vid_addr[HBIT];
      endcase
   end

endmodule

// File: rtl/chr_bank_mapper.sv
module chr_bank_mapper
   import chr_map_pkg::*;
#(
   parameter int                CPU_AW = 16,
   parameter int                CPU_DW = 8,
   parameter int                VAW    = 13,
   parameter int                ROM_AW = 18,
   parameter logic [CPU_AW-1:0] BASE   = 16'h7EF0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_we,
   input  logic [CPU_AW-1:0] cpu_addr,
   input  logic [CPU_DW-1:0] cpu_wdata,
   input  logic [VAW-1:0]    vid_addr,
   output logic [ROM_AW-1:0] rom_addr,
   output logic              nt_addr_bit
);

   localparam int OFS_W = VAW - 3;

   if (ROM_AW != CPU_DW + OFS_W) begin : g_bad_rom
      $error("chr_bank_mapper: ROM_AW must equal CPU_DW + VAW - 3");
   end

   logic [NUM_BANKS-1:0][CPU_DW-1:0]  bank_q;
   logic [NUM_WIDE-1:0][CPU_DW-1:0]   wide_bank;
   logic [NUM_NARROW-1:0][CPU_DW-1:0] narrow_bank;
   ctrl_t                             ctrl_q;

   chr_bank_regs #(
      .ADDR_W (CPU_AW),
      .DATA_W (CPU_DW),
      .BASE   (BASE)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (cpu_we),
      .addr   (cpu_addr),
      .wdata  (cpu_wdata),
      .bank_q (bank_q),
      .ctrl_q (ctrl_q)
   );

   for (genvar i = 0; i < NUM_WIDE; i++) begin : g_wide
      assign wide_bank[i] = bank_q[i];
   end
   for (genvar j = 0; j < NUM_NARROW; j++) begin : g_narrow
      assign narrow_bank[j] = bank_q[NUM_WIDE + j];
   end

   chr_window_decode #(
      .VAW    (VAW),
      .BANK_W (CPU_DW),
      .ROM_AW (ROM_AW)
   ) u_decode (
      .vid_addr    (vid_addr),
      .wide_bank   (wide_bank),
      .narrow_bank (narrow_bank),
      .swap        (ctrl_q.swap),
      .rom_addr    (rom_addr)
   );

   chr_mirror_sel #(
      .VAW (VAW)
   ) u_mirror (
      .vid_addr (vid_addr),
      .mir      (ctrl_q.mir),
      .nt_bit   (nt_addr_bit)
   );

   // R4: offset passes through untouched
   a_r4_offset: assert property (@(posedge clk) disable iff (!rst_n)
      rom_addr[OFS_W-1:0] == vid_addr[OFS_W-1:0]);

   // R2: wide window bank is register bits 7..1 plus video bit 10
   a_r2_wide: assert property (@(posedge clk) disable iff (!rst_n)
      (vid_addr[VAW-1] == ctrl_q.swap) |->
         (rom_addr[ROM_AW-1:OFS_W+1] == wide_bank[vid_addr[VAW-2]][CPU_DW-1:1]
          && rom_addr[OFS_W] == vid_addr[OFS_W]));

   // R3: narrow window bank is the full register
   a_r3_narrow: assert property (@(posedge clk) disable iff (!rst_n)
      (vid_addr[VAW-1] != ctrl_q.swap) |->
         (rom_addr[ROM_AW-1:OFS_W] == narrow_bank[vid_addr[VAW-2:VAW-3]]));

   // R10: nametable bit follows mirroring mode
   a_r10_mirror: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.mir == MIR_HORIZ) ? (nt_addr_bit == vid_addr[VAW-2])
                                : (nt_addr_bit == vid_addr[VAW-3]));

endmodule

// File: tb/tb_chr_bank_mapper.sv
module tb_chr_bank_mapper;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_we = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic [12:0] vid_addr = '0;
   logic [17:0] rom_addr;
   logic        nt_addr_bit;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // shadow state built from the requirements
   logic [7:0] sh_bank [6];
   logic       sh_swap;
   logic       sh_vert;

   always #2.5 clk = ~clk;   // 200 MHz

   chr_bank_mapper dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .cpu_we      (cpu_we),
      .cpu_addr    (cpu_addr),
      .cpu_wdata   (cpu_wdata),
      .vid_addr    (vid_addr),
      .rom_addr    (rom_addr),
      .nt_addr_bit (nt_addr_bit)
   );

   // vector: [24] 0=write 1=probe, [23:8] address, [7:0] data
   localparam int NV = 22;
   localparam logic [24:0] VEC [NV] = '{
      {1'b0, 16'h7EF0, 8'h35},   // wide reg 0 with bit0 set (R2)
      {1'b0, 16'h7EF1, 8'h8A},
      {1'b0, 16'h7EF2, 8'h11},
      {1'b0, 16'h7EF3, 8'h22},
      {1'b0, 16'h7EF4, 8'hC3},
      {1'b0, 16'h7EF5, 8'hFF},
      {1'b1, 16'h0000, 8'h00},
      {1'b1, 16'h0400, 8'h00},
      {1'b1, 16'h07FF, 8'h00},
      {1'b1, 16'h0800, 8'h00},
      {1'b1, 16'h0C01, 8'h00},
      {1'b1, 16'h1000, 8'h00},
      {1'b1, 16'h1405, 8'h00},
      {1'b1, 16'h1800, 8'h00},
      {1'b1, 16'h1FFF, 8'h00},
      {1'b0, 16'h7EF6, 8'h02},   // swap on (R6)
      {1'b1, 16'h0000, 8'h00},
      {1'b1, 16'h0BFE, 8'h00},
      {1'b1, 16'h0FFF, 8'h00},
      {1'b1, 16'h1000, 8'h00},
      {1'b1, 16'h1C00, 8'h00},
      {1'b1, 16'h1FFF, 8'h00}
   };

   function automatic logic [17:0] model_rom(input logic [12:0] va);
      logic       hi;
      logic [7:0] b;
      hi = va[12] ^ sh_swap;
      if (!hi) b = {sh_bank[va[11]][7:1], va[10]};
      else     b = sh_bank[2 + va[11:10]];
      return {b, va[9:0]};
   endfunction

   function automatic logic model_nt(input logic [12:0] va);
      return sh_vert ? va[10] : va[11];
   endfunction

   task automatic clear_shadow();
      for (int i = 0; i < 6; i++) sh_bank[i] = 8'h00;
      sh_swap = 1'b0;
      sh_vert = 1'b0;
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic en);
      @(negedge clk);
      cpu_we    = en;
      cpu_addr  = a;
      cpu_wdata = d;
      @(negedge clk);
      cpu_we    = 1'b0;
      if (en && a >= 16'h7EF0 && a <= 16'h7EF5) sh_bank[a - 16'h7EF0] = d;
      else if (en && a == 16'h7EF6) begin
         sh_vert = d[0];
         sh_swap = d[1];
      end
   endtask

   task automatic probe(input logic [12:0] va, input string tag);
      logic [17:0] er;
      logic        en;
      @(negedge clk);
      vid_addr = va;
      #1;
      er = model_rom(va);
      en = model_nt(va);
      checks++;
      if (rom_addr !== er) begin
         errors++;
         $display("FAIL %s rom_addr vid=%h actual=%h expected=%h", tag, va, rom_addr, er);
      end
      checks++;
      if (nt_addr_bit !== en) begin
         errors++;
         $display("FAIL %s nt_addr_bit vid=%h actual=%b expected=%b", tag, va, nt_addr_bit, en);
      end
   endtask

   initial begin : watchdog
      for (int c = 0; c < 100000; c++) begin
         @(posedge clk);
         if (done) disable watchdog;
      end
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      clear_shadow();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      probe(13'h0000, "R1");
      probe(13'h0C00, "R1");
      probe(13'h1FFF, "R1");

      // table walk: R2 R3 R4 R5 R6 R7 R10
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][24]) probe(VEC[i][20:8], "R5_R6_table");
         else            wr(VEC[i][23:8], VEC[i][7:0], 1'b1);
      end

      // R2: explicit numbers for bit0-discard, swap off
      wr(16'h7EF6, 8'h00, 1'b1);
      @(negedge clk); vid_addr = 13'h0000; #1;
      checks++;
      if (rom_addr !== 18'h0D000) begin
         errors++;
         $display("FAIL R2 actual=%h expected=%h", rom_addr, 18'h0D000);
      end
      @(negedge clk); vid_addr = 13'h0401; #1;
      checks++;
      if (rom_addr !== 18'h0D401) begin
         errors++;
         $display("FAIL R2 actual=%h expected=%h", rom_addr, 18'h0D401);
      end
      // R3: full 8-bit narrow bank
      @(negedge clk); vid_addr = 13'h1800; #1;
      checks++;
      if (rom_addr !== 18'h30C00) begin
         errors++;
         $display("FAIL R3 actual=%h expected=%h", rom_addr, 18'h30C00);
      end

      // R8: unused control bits ignored; vertical mirroring
      wr(16'h7EF6, 8'hFC, 1'b1);
      probe(13'h0C00, "R8");
      probe(13'h1400, "R8");
      wr(16'h7EF6, 8'h01, 1'b1);
      probe(13'h0400, "R10");
      probe(13'h0800, "R10");
      wr(16'h7EF6, 8'h03, 1'b1);
      probe(13'h0400, "R6_R10");
      probe(13'h1C00, "R6_R10");

      // R9: neighbouring addresses, alias and disabled strobe
      wr(16'h7EEF, 8'h55, 1'b1);
      wr(16'h7EF7, 8'h55, 1'b1);
      wr(16'h3EF0, 8'h55, 1'b1);
      wr(16'hFEF2, 8'h55, 1'b1);
      wr(16'h7EF0, 8'h55, 1'b0);
      wr(16'h7EF6, 8'h00, 1'b0);
      for (int k = 0; k < 8; k++) probe(13'(k * 13'h0400 + k), "R9");

      // R7: overwrite a register and see it immediately
      wr(16'h7EF3, 8'h9C, 1'b1);
      probe(13'h0555, "R7");

      // R1: reset in the middle of a run clears everything
      @(negedge clk);
      rst_n = 1'b0;
      clear_shadow();
      @(negedge clk);
      rst_n = 1'b1;
      probe(13'h0BFF, "R1");
      probe(13'h1C3A, "R1");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule